// File: doc/BRIEF.md
# Section Domain and Permission Checker

This block decides whether one memory access to a mapped section may go ahead. For each request it takes the fields already pulled out of the section entry: a domain number, a 3-bit access permission code and an execute-never flag. It also takes the kind of access (read, write or instruction fetch) and whether the requester is privileged. One clock later it returns either an allow decision or a fault class. The fault classes are domain fault, execute-never fault and permission fault.

A 32-bit domain control register holds one 2-bit field per domain. Software loads the whole register through a single-cycle write port. Each field decides how its domain is treated before any permission decoding is done. A domain can deny every access, have its accesses checked against the entry's permission code, or allow every access with no check at all. The register clears on reset, so every domain faults until software writes the register.

Top module: `sect_access_checker`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rsp_valid` is 0. The domain control register resets to all zeros, so the first request after reset gives a domain fault.
- R2: When `dctl_wr_en` is high at a clock edge, the whole register is loaded from `dctl_wr_data`. Domain d uses bits 2d+1:2d. A request sampled at the same edge as the write is checked against the old value. Requests sampled at later edges use the new value.
- R3: A request sampled at a clock edge has its result on `rsp_valid`/`rsp_allow`/`rsp_fault` right after that edge. When `req_valid` was low, the outputs are `rsp_valid`=0, `rsp_allow`=0 and `rsp_fault`=00.
- R4: A domain field of 00 (deny) or 10 (reserved) gives `rsp_fault`=01 (domain fault) for every access. This holds whatever the permission code and the execute-never flag are.
- R5: A domain field of 11 (manager) allows every access. Neither the permission code nor the execute-never flag is examined.
- R6: With a domain field of 01 (client), an instruction fetch with `req_xn`=1 gives `rsp_fault`=10 (execute-never fault). This fault takes priority over any permission result.
- R7: With a client domain, the permission code grants the following; any other access gives `rsp_fault`=11.
  - Code 000 grants nothing to either level.
  - Code 001 grants privileged read/write and nothing to user.
  - Code 010 grants privileged read/write and user read.
  - Code 011 grants read/write to both levels.
  - Code 101 grants privileged read only.
  - Codes 110 and 111 grant read only to both levels.
- R8: Permission code 100 is reserved. With a client domain it gives `rsp_fault`=11 for every read, write and non-execute-never fetch, at both privilege levels.
- R9: `req_kind` encodes 00 as read, 01 as write and 10 as instruction fetch. Code 11 is checked as a write. A fetch needs read permission.
- R10: For every valid response, exactly one outcome is reported: either `rsp_allow`=1 with `rsp_fault`=00, or `rsp_allow`=0 with a non-zero fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dctl_wr_en | input | 1 | Load the domain control register |
| dctl_wr_data | input | 32 | New domain control value, 2 bits per domain |
| req_valid | input | 1 | A request is presented this cycle |
| req_domain | input | 4 | Domain number from the section entry |
| req_ap | input | 3 | Access permission code from the section entry |
| req_xn | input | 1 | Execute-never flag from the section entry |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 write |
| req_priv | input | 1 | 1 for a privileged requester |
| rsp_valid | output | 1 | Registered: a result is present |
| rsp_allow | output | 1 | Registered: the access is allowed |
| rsp_fault | output | 2 | Registered: 00 none, 01 domain, 10 execute-never, 11 permission |

## Verification
The bench builds the block with its default of 16 domains. This brings every 2-bit field position of the 32-bit control register into reach, including the top domain at bits 31:30. A write that sets a single domain to manager while the others stay zero shows that fields do not leak into their neighbours. A full sweep of all permission codes, access kinds and privilege levels on a client domain covers the decoding. Random control values and requests then mix all four field codes with back-to-back writes and requests, including a write in the same cycle as a request.

// File: rtl/sect_chk_pkg.sv
package sect_chk_pkg;

  localparam int FIELD_W = 2;
  localparam int AP_W    = 3;
  localparam int KIND_W  = 2;
  localparam int FAULT_W = 2;

  localparam logic [FIELD_W-1:0] DCTL_DENY   = 2'b00;
  localparam logic [FIELD_W-1:0] DCTL_CLIENT = 2'b01;
  localparam logic [FIELD_W-1:0] DCTL_RSVD   = 2'b10;
  localparam logic [FIELD_W-1:0] DCTL_MGR    = 2'b11;

  localparam logic [KIND_W-1:0] KIND_READ  = 2'b00;
  localparam logic [KIND_W-1:0] KIND_WRITE = 2'b01;
  localparam logic [KIND_W-1:0] KIND_FETCH = 2'b10;

  localparam logic [FAULT_W-1:0] FLT_NONE   = 2'b00;
  localparam logic [FAULT_W-1:0] FLT_DOMAIN = 2'b01;
  localparam logic [FAULT_W-1:0] FLT_XN     = 2'b10;
  localparam logic [FAULT_W-1:0] FLT_PERM   = 2'b11;

  // Level index into the decoder outputs
  localparam int LVL_USER = 0;
  localparam int LVL_PRIV = 1;
  localparam int NUM_LVL  = 2;

endpackage

// File: rtl/sect_dctl_reg.sv
module sect_dctl_reg
  import sect_chk_pkg::*;
#(
  parameter int NUM_DOM = 16,
  localparam int REG_W  = NUM_DOM * FIELD_W,
  localparam int IDX_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]   sel_dom,
  output logic [FIELD_W-1:0] sel_field
);

  logic [REG_W-1:0]   dctl_q;
  logic [FIELD_W-1:0] fields [NUM_DOM];

  always_ff @(posedge clk) begin
    if (rst) begin
      dctl_q <= '0;
    end else if (wr_en) begin
      dctl_q <= wr_data;
    end
  end

  // Split the flat register into per-domain fields
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_field
    assign fields[d] = dctl_q[d*FIELD_W +: FIELD_W];
  end

  // Domain numbers beyond the populated range read as deny
  always_comb begin
    if (int'(sel_dom) < NUM_DOM) begin
      sel_field = fields[sel_dom];
    end else begin
      sel_field = DCTL_DENY;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dctl_q == '0));

  p_write_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en)) |-> (dctl_q == $past(wr_data)));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> $stable(dctl_q));

endmodule

// File: rtl/sect_ap_decode.sv
module sect_ap_decode
  import sect_chk_pkg::*;
(
  input  logic [AP_W-1:0]    ap,
  output logic [NUM_LVL-1:0] rd_ok,
  output logic [NUM_LVL-1:0] wr_ok
);

  // One decoder per privilege level; level 1 is privileged
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic lvl_rd;
    logic lvl_wr;

    if (g == LVL_PRIV) begin : g_priv
      always_comb begin
        unique case (ap)
          3'b001, 3'b010, 3'b011: begin lvl_rd = 1'b1; lvl_wr = 1'b1; end
          3'b101, 3'b110, 3'b111: begin lvl_rd = 1'b1; lvl_wr = 1'b0; end
          default:                begin lvl_rd = 1'b0; lvl_wr = 1'b0; end
        endcase
      end
    end else begin : g_user
      always_comb begin
        unique case (ap)
          3'b011:                 begin lvl_rd = 1'b1; lvl_wr = 1'b1; end
          3'b010, 3'b110, 3'b111: begin lvl_rd = 1'b1; lvl_wr = 1'b0; end
          default:                begin lvl_rd = 1'b0; lvl_wr = 1'b0; end
        endcase
      end
    end

    assign rd_ok[g] = lvl_rd;
    assign wr_ok[g] = lvl_wr;
  end

  // Write is never granted without read at the same level
  always_comb begin
    a_wr_implies_rd_r7: assert ((wr_ok & ~rd_ok) == '0);
  end

endmodule

// File: rtl/sect_fault_resolve.sv
module sect_fault_resolve
  import sect_chk_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [FIELD_W-1:0] dom_field,
  input  logic [KIND_W-1:0]  req_kind,
  input  logic               req_priv,
  input  logic               req_xn,
  input  logic [AP_W-1:0]    req_ap,
  input  logic [NUM_LVL-1:0] rd_ok,
  input  logic [NUM_LVL-1:0] wr_ok,
  output logic               rsp_valid,
  output logic               rsp_allow,
  output logic [FAULT_W-1:0] rsp_fault
);

  logic               is_fetch;
  logic               is_write;
  logic               granted;
  logic               nxt_allow;
  logic [FAULT_W-1:0] nxt_fault;

  assign is_fetch = (req_kind == KIND_FETCH);
  assign is_write = req_kind[0];
  assign granted  = is_write ? wr_ok[req_priv] : rd_ok[req_priv];

  // Priority: domain, then execute-never, then permission
  always_comb begin
    nxt_allow = 1'b0;
    nxt_fault = FLT_NONE;
    if (!dom_field[0]) begin
      nxt_fault = FLT_DOMAIN;
    end else if (dom_field == DCTL_MGR) begin
      nxt_allow = 1'b1;
    end else if (is_fetch && req_xn) begin
      nxt_fault = FLT_XN;
    end else if (granted) begin
      nxt_allow = 1'b1;
    end else begin
      nxt_fault = FLT_PERM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_fault <= FLT_NONE;
    end else begin
      rsp_valid <= req_valid;
      rsp_allow <= req_valid && nxt_allow;
      rsp_fault <= req_valid ? nxt_fault : FLT_NONE;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid);

  p_valid_follow_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rsp_valid == $past(req_valid)));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_allow && rsp_fault == FLT_NONE));

  p_dom_fault_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !dom_field[0]) |=> (rsp_fault == FLT_DOMAIN && !rsp_allow));

  p_mgr_allow_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && dom_field == DCTL_MGR) |=> rsp_allow);

  p_xn_fault_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && dom_field == DCTL_CLIENT && is_fetch && req_xn)
      |=> (rsp_fault == FLT_XN));

  p_rsvd_ap_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && dom_field == DCTL_CLIENT && req_ap == 3'b100 &&
     !(is_fetch && req_xn)) |=> (rsp_fault == FLT_PERM));

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_allow != (rsp_fault != FLT_NONE)));

endmodule

// File: rtl/sect_access_checker.sv
module sect_access_checker
  import sect_chk_pkg::*;
#(
  parameter int NUM_DOM = 16,
  localparam int REG_W  = NUM_DOM * FIELD_W,
  localparam int IDX_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dctl_wr_en,
  input  logic [REG_W-1:0]   dctl_wr_data,
  input  logic               req_valid,
  input  logic [IDX_W-1:0]   req_domain,
  input  logic [AP_W-1:0]    req_ap,
  input  logic               req_xn,
  input  logic [KIND_W-1:0]  req_kind,
  input  logic               req_priv,
  output logic               rsp_valid,
  output logic               rsp_allow,
  output logic [FAULT_W-1:0] rsp_fault
);

  logic [FIELD_W-1:0] dom_field;
  logic [NUM_LVL-1:0] rd_ok;
  logic [NUM_LVL-1:0] wr_ok;

  sect_dctl_reg #(.NUM_DOM(NUM_DOM)) u_dctl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (dctl_wr_en),
    .wr_data   (dctl_wr_data),
    .sel_dom   (req_domain),
    .sel_field (dom_field)
  );

  sect_ap_decode u_apdec (
    .ap    (req_ap),
    .rd_ok (rd_ok),
    .wr_ok (wr_ok)
  );

  sect_fault_resolve u_resolve (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .dom_field (dom_field),
    .req_kind  (req_kind),
    .req_priv  (req_priv),
    .req_xn    (req_xn),
    .req_ap    (req_ap),
    .rd_ok     (rd_ok),
    .wr_ok     (wr_ok),
    .rsp_valid (rsp_valid),
    .rsp_allow (rsp_allow),
    .rsp_fault (rsp_fault)
  );

endmodule

// File: tb/sect_access_checker_bench.sv
`timescale 1ns/1ps
module sect_access_checker_bench;

  localparam int NUM_DOM = 16;
  localparam int REG_W   = NUM_DOM * 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             dctl_wr_en = 1'b0;
  logic [REG_W-1:0] dctl_wr_data = '0;
  logic             req_valid = 1'b0;
  logic [3:0]       req_domain = '0;
  logic [2:0]       req_ap = '0;
  logic             req_xn = 1'b0;
  logic [1:0]       req_kind = '0;
  logic             req_priv = 1'b0;
  logic             rsp_valid;
  logic             rsp_allow;
  logic [1:0]       rsp_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [REG_W-1:0] model = '0;

  always #2 clk = ~clk;

  sect_access_checker #(.NUM_DOM(NUM_DOM)) u_sect_access_checker (
    .clk(clk), .rst(rst), .dctl_wr_en(dctl_wr_en), .dctl_wr_data(dctl_wr_data),
    .req_valid(req_valid), .req_domain(req_domain), .req_ap(req_ap),
    .req_xn(req_xn), .req_kind(req_kind), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault)
  );

  // Expected {valid, allow, fault[1:0]} for a valid request
  function automatic logic [3:0] expect_rsp(input logic [REG_W-1:0] dc, input int dom,
      input logic [2:0] ap, input logic xn, input logic [1:0] kind, input logic priv);
    logic [1:0] f;
    logic rd, wr, need_wr;
    f = dc[2*dom +: 2];
    need_wr = (kind == 2'b01) || (kind == 2'b11);
    if (f == 2'b00 || f == 2'b10) return 4'b1001;
    if (f == 2'b11) return 4'b1100;
    if (kind == 2'b10 && xn) return 4'b1010;
    rd = 1'b0; wr = 1'b0;
    if (priv) begin
      case (ap)
        3'b001, 3'b010, 3'b011: begin rd = 1'b1; wr = 1'b1; end
        3'b101, 3'b110, 3'b111: rd = 1'b1;
        default: ;
      endcase
    end else begin
      case (ap)
        3'b011: begin rd = 1'b1; wr = 1'b1; end
        3'b010, 3'b110, 3'b111: rd = 1'b1;
        default: ;
      endcase
    end
    if (need_wr ? wr : rd) return 4'b1100;
    return 4'b1011;
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] got;
    got = {rsp_valid, rsp_allow, rsp_fault};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive_req(input int dom, input logic [2:0] ap, input logic xn,
      input logic [1:0] kind, input logic priv);
    req_valid = 1'b1;
    req_domain = 4'(dom);
    req_ap = ap;
    req_xn = xn;
    req_kind = kind;
    req_priv = priv;
  endtask

  task automatic do_req(input string tag, input int dom, input logic [2:0] ap,
      input logic xn, input logic [1:0] kind, input logic priv);
    logic [3:0] e;
    @(negedge clk);
    dctl_wr_en = 1'b0;
    drive_req(dom, ap, xn, kind, priv);
    e = expect_rsp(model, dom, ap, xn, kind, priv);
    @(posedge clk);
    #1;
    check(tag, e);
  endtask

  task automatic put_dctl(input logic [REG_W-1:0] v);
    @(negedge clk);
    req_valid = 1'b0;
    dctl_wr_en = 1'b1;
    dctl_wr_data = v;
    @(posedge clk);
    model = v;
    #1;
    dctl_wr_en = 1'b0;
  endtask

  initial begin
    logic [3:0] e;
    void'($urandom(32'd20240117));
    // R1: outputs idle during reset even with a request presented
    drive_req(0, 3'b011, 1'b0, 2'b00, 1'b1);
    repeat (3) @(posedge clk);
    #1;
    check("R1 idle in reset", 4'b0000);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    // R1: register cleared, so domain fault for a full-access entry
    check("R1 cleared register faults", 4'b1001);

    // R3: idle request gives quiet outputs
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R3 idle response", 4'b0000);

    // R2: only domain 5 becomes manager; neighbours stay denied; top field
    put_dctl(32'h0000_0C00);
    do_req("R2 domain5 manager", 5, 3'b000, 1'b1, 2'b10, 1'b0);
    do_req("R2 domain4 still denied", 4, 3'b011, 1'b0, 2'b00, 1'b1);
    do_req("R2 domain6 still denied", 6, 3'b011, 1'b0, 2'b00, 1'b1);
    put_dctl(32'h4000_0000);
    do_req("R2 top domain client", 15, 3'b011, 1'b0, 2'b01, 1'b0);

    // R4: reserved field 10 on domain 2, deny on domain 3
    put_dctl(32'h0000_0020);
    do_req("R4 reserved field faults", 2, 3'b011, 1'b0, 2'b00, 1'b1);
    do_req("R4 deny field faults", 3, 3'b011, 1'b1, 2'b10, 1'b1);

    // R5: manager ignores AP and XN
    put_dctl(32'hFFFF_FFFF);
    do_req("R5 manager ap000 user write", 9, 3'b000, 1'b0, 2'b01, 1'b0);
    do_req("R5 manager xn fetch", 0, 3'b100, 1'b1, 2'b10, 1'b0);

    // R6/R7/R8/R9: client sweep over every ap, kind, level, xn
    put_dctl(32'h5555_5555);
    for (int a = 0; a < 8; a++)
      for (int k = 0; k < 4; k++)
        for (int p = 0; p < 2; p++)
          for (int x = 0; x < 2; x++)
            do_req((a == 4) ? "R8 reserved ap sweep" :
                   (k == 3) ? "R9 kind11 as write" :
                   (k == 2 && x == 1) ? "R6 xn fetch" : "R7 client ap sweep",
                   a + 3, 3'(a), 1'(x), 2'(k), 1'(p));

    // R2: write and request in the same cycle use the old value
    @(negedge clk);
    dctl_wr_en = 1'b1;
    dctl_wr_data = 32'h0;
    drive_req(1, 3'b011, 1'b0, 2'b00, 1'b0);
    e = expect_rsp(model, 1, 3'b011, 1'b0, 2'b00, 1'b0);
    @(posedge clk);
    model = 32'h0;
    #1;
    check("R2 same-cycle write uses old value", e);
    do_req("R2 next request uses new value", 1, 3'b011, 1'b0, 2'b00, 1'b0);

    // R10 and all others: random mix
    for (int i = 0; i < 3000; i++) begin
      if ((i % 8) == 0) put_dctl($urandom);
      do_req("R10 random", int'($urandom_range(15, 0)), 3'($urandom), 1'($urandom),
             2'($urandom), 1'($urandom));
      if (rsp_valid && (rsp_allow == (rsp_fault != 2'b00))) begin
        errors++;
        $display("FAIL R10: allow %b fault %b expected exactly one outcome",
                 rsp_allow, rsp_fault);
      end
    end

    // R3: valid drops after a run of requests
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R3 idle after traffic", 4'b0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule